// File: doc/BRIEF.md
# Receive Payload Extractor with Gapped Clock

This block sits on the receive side of a framed serial link. It runs on the line bit clock, one received bit per cycle. It keeps its own count of frame position and labels every bit on the receive data line. A strobe goes high on overhead bits, which are the leading sync field and the optional trailing stuff field. A marker goes low on the first bit of each frame. An enable goes high on payload bits once the link is up, so a downstream consumer can use it as a gapped payload clock. A running count reports how many payload bits of the current frame have already passed.

Two frame lengths are supported, selected by a mode pin. The short mode has 4688 payload bits and the long mode has 6992; the modes differ in nothing else. On the last payload bit the block samples a per-frame stuff flag. The flag decides whether the frame closes there or carries four stuff bits first. Until the active-low link status goes low, the receive data line is forced high. Clock recovery and sync-word search belong to other blocks. Frame bit 1 is the first cycle after reset is released.

The payload enable acts as the valid of the output stream, and there is no ready. The bit rate is set by the line, so the consumer must take every bit on which the enable is high. It cannot apply back-pressure.

Top module: `rpx_rx_extract`

## Requirements
- R1: During reset and in the first cycle after reset is released, the block presents frame bit 1: the frame marker is low, the strobe is high and the payload count is 0.
- R2: The overhead strobe is high on frame bits 1 to 14, which form the sync field.
- R3: The frame marker is low on frame bit 1 only and high on every other bit.
- R4: With mode 0 the payload occupies bits 15 to 4702, and with mode 1 it occupies bits 15 to 7006. The strobe is low on all of these bits.
- R5: The stuff flag is sampled only on the last payload bit. If it is 1 there, four stuff bits follow with the strobe high, and then the next frame starts. If it is 0, the next frame starts at once. Its value on every other bit has no effect.
- R6: While link status is 1 (link not active), the receive data output is 1. While link status is 0, the output equals the received bit in the same cycle.
- R7: The payload enable is 1 exactly when the strobe is low and link status is 0.
- R8: The payload count equals the number of payload bits already passed in the current frame. It is 0 from bit 1 through bit 15 and holds the full payload length during stuff bits.
- R9: The mode pin is sampled on the last bit of a frame and while reset is asserted. It sets the length of the next frame, and changes on any other bit have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line bit clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | Frame length select: 0 short, 1 long |
| stuff_i | input | 1 | Stuff flag, sampled on the last payload bit |
| rx_bit_i | input | 1 | Received serial bit |
| link_act_ni | input | 1 | Link status, 0 when the link is active |
| rx_data_o | output | 1 | Receive data, forced to 1 until the link is active |
| ovh_stb_o | output | 1 | High on sync and stuff bits |
| frame_mk_no | output | 1 | Low on frame bit 1 |
| pay_vld_o | output | 1 | Payload enable, usable as a gapped clock enable |
| pay_cnt_o | output | CNT_W (13) | Payload bits already passed in this frame |

## Verification
The bench runs whole frames in both modes, with and without stuff bits. During each frame the stuff flag is driven to the opposite value on every bit except the last payload bit. A design that sampled the flag one bit early or late would then make frames four bits too long or too short, and every later marker would land in the wrong place. The mode pin is also flipped in the middle of frames, so a design that took up a new mode mid-frame would move the end of the payload. The link status is toggled inside a frame to catch data or enable outputs that are not properly gated. The payload count is checked on the boundary bits 14, 15 and the last payload bit, where an off-by-one error would show.

// File: rtl/rpx_pkg.sv
package rpx_pkg;
  localparam int SYNC_BITS_D  = 14;
  localparam int PAY_SHORT_D  = 4688;
  localparam int PAY_LONG_D   = 6992;
  localparam int STUFF_BITS_D = 4;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/rpx_frame_ctr.sv
module rpx_frame_ctr
  import rpx_pkg::*;
#(
  parameter int SYNC_BITS  = SYNC_BITS_D,
  parameter int PAY_SHORT  = PAY_SHORT_D,
  parameter int PAY_LONG   = PAY_LONG_D,
  parameter int STUFF_BITS = STUFF_BITS_D,
  parameter int POS_W      = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             stuff_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] pay_end_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] END_SHORT = POS_W'(SYNC_BITS + PAY_SHORT);
  localparam logic [POS_W-1:0] END_LONG  = POS_W'(SYNC_BITS + PAY_LONG);
  localparam logic [POS_W-1:0] STUFF_LEN = POS_W'(STUFF_BITS);

  frame_mode_e      mode_q;
  logic [POS_W-1:0] pos_q;
  logic             at_pay_end;

  assign pay_end_o  = (mode_q == MODE_LONG) ? END_LONG : END_SHORT;
  assign at_pay_end = (pos_q == pay_end_o);
  assign last_o     = (at_pay_end && !stuff_i) || (pos_q == pay_end_o + STUFF_LEN);
  assign pos_o      = pos_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pos_q  <= POS_W'(1);
      mode_q <= frame_mode_e'(mode_i);
    end else if (last_o) begin
      pos_q  <= POS_W'(1);
      mode_q <= frame_mode_e'(mode_i);
    end else begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  a_r5_close_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_pay_end && !stuff_i) |=> (pos_q == POS_W'(1)));
  a_r5_enter_stuff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_pay_end && stuff_i) |=> (pos_q == $past(pay_end_o) + 1'b1));
  a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != '0) && (pos_q <= pay_end_o + STUFF_LEN));
  a_r9_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> $stable(mode_q));
endmodule

// File: rtl/rpx_tagger.sv
module rpx_tagger #(
  parameter int SYNC_BITS = 14,
  parameter int POS_W     = 13
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] pay_end_i,
  input  logic             rx_bit_i,
  input  logic             link_act_ni,
  output logic             rx_data_o,
  output logic             ovh_stb_o,
  output logic             frame_mk_no,
  output logic             pay_vld_o
);
  localparam logic [POS_W-1:0] SYNC_END = POS_W'(SYNC_BITS);

  logic in_sync, in_stuff;

  always_comb begin
    in_sync     = (pos_i <= SYNC_END);
    in_stuff    = (pos_i > pay_end_i);
    ovh_stb_o   = in_sync || in_stuff;
    frame_mk_no = (pos_i != POS_W'(1));
    rx_data_o   = link_act_ni ? 1'b1 : rx_bit_i;
    pay_vld_o   = !ovh_stb_o && !link_act_ni;
  end
endmodule

// File: rtl/rpx_pay_count.sv
module rpx_pay_count #(
  parameter int PAY_LONG = 6992,
  parameter int CNT_W    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             payload_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (last_i)    cnt_q <= '0;
    else if (payload_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r8_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PAY_LONG));
  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (payload_i && !last_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rpx_rx_extract.sv
module rpx_rx_extract
  import rpx_pkg::*;
#(
  parameter int SYNC_BITS  = SYNC_BITS_D,
  parameter int PAY_SHORT  = PAY_SHORT_D,
  parameter int PAY_LONG   = PAY_LONG_D,
  parameter int STUFF_BITS = STUFF_BITS_D,
  localparam int POS_W     = $clog2(SYNC_BITS + PAY_LONG + STUFF_BITS + 1),
  localparam int CNT_W     = $clog2(PAY_LONG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             stuff_i,
  input  logic             rx_bit_i,
  input  logic             link_act_ni,
  output logic             rx_data_o,
  output logic             ovh_stb_o,
  output logic             frame_mk_no,
  output logic             pay_vld_o,
  output logic [CNT_W-1:0] pay_cnt_o
);
  logic [POS_W-1:0] pos, pay_end;
  logic             last;

  rpx_frame_ctr #(
    .SYNC_BITS(SYNC_BITS), .PAY_SHORT(PAY_SHORT), .PAY_LONG(PAY_LONG),
    .STUFF_BITS(STUFF_BITS), .POS_W(POS_W)
  ) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .stuff_i(stuff_i),
    .pos_o(pos), .pay_end_o(pay_end), .last_o(last)
  );

  rpx_tagger #(.SYNC_BITS(SYNC_BITS), .POS_W(POS_W)) u_tag (
    .pos_i(pos), .pay_end_i(pay_end), .rx_bit_i(rx_bit_i),
    .link_act_ni(link_act_ni), .rx_data_o(rx_data_o), .ovh_stb_o(ovh_stb_o),
    .frame_mk_no(frame_mk_no), .pay_vld_o(pay_vld_o)
  );

  rpx_pay_count #(.PAY_LONG(PAY_LONG), .CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .payload_i(!ovh_stb_o), .last_i(last),
    .cnt_o(pay_cnt_o)
  );

  a_r3_mark_in_ovh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_mk_no |-> ovh_stb_o);
  a_r3_mark_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_mk_no |=> frame_mk_no);
  a_r6_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_act_ni |-> rx_data_o);
  a_r7_vld_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_o |-> (!ovh_stb_o && !link_act_ni));
  a_r8_zero_at_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_mk_no |-> (pay_cnt_o == '0));
  a_r4_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == pay_end) |-> (pay_cnt_o == CNT_W'(pay_end - POS_W'(SYNC_BITS) - 1'b1)));
endmodule

// File: tb/test_rpx_rx_extract.sv
`timescale 1ns/1ps
module test_rpx_rx_extract;
  localparam int SYNC = 14;
  localparam int STF  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni, mode_i, stuff_i, rx_bit_i, link_act_ni;
  logic        rx_data_o, ovh_stb_o, frame_mk_no, pay_vld_o;
  logic [12:0] pay_cnt_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk_i = ~clk_i;

  rpx_rx_extract i_rpx_rx_extract (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .stuff_i(stuff_i),
    .rx_bit_i(rx_bit_i), .link_act_ni(link_act_ni), .rx_data_o(rx_data_o),
    .ovh_stb_o(ovh_stb_o), .frame_mk_no(frame_mk_no), .pay_vld_o(pay_vld_o),
    .pay_cnt_o(pay_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp, input int bitno);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      if (n_fail <= 12)
        $display("FAIL %s bit %0d: actual %0d expected %0d", req, bitno, act, exp);
    end
  endtask

  // R1: reset state, checked in the first cycle after release
  task automatic t_reset();
    rst_ni = 1'b0; mode_i = 1'b0; stuff_i = 1'b0; rx_bit_i = 1'b0; link_act_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 marker in reset", frame_mk_no, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 marker", frame_mk_no, 0, 1);
    chk("R1 strobe", ovh_stb_o, 1, 1);
    chk("R1 count", pay_cnt_o, 0, 1);
    chk("R6 idle data", rx_data_o, 1, 1);
  endtask

  // One frame; lnk: 0 idle, 1 active, 2 toggling every 8 bits
  task automatic t_frame(input bit md, input bit st, input int lnk, input bit nxt);
    int pe  = SYNC + (md ? 6992 : 4688);
    int len = pe + (st ? STF : 0);
    for (int b = 1; b <= len; b++) begin
      bit la  = (lnk == 1) || (lnk == 2 && ((b >> 3) & 1) == 1);
      bit rb  = 1'($urandom_range(0, 1));
      bit ovh = (b <= SYNC) || (b > pe);
      int ec  = (b <= SYNC) ? 0 : ((b <= pe) ? b - SYNC - 1 : pe - SYNC);
      rx_bit_i    = rb;
      link_act_ni = !la;
      stuff_i     = (b == pe) ? st : !st;                     // R5: only bit pe matters
      mode_i      = (b == len) ? nxt : ((b > 100 && b < 140) ? !md : md); // R9
      #1;
      chk(b == 1 ? "R9 frame start" : "R3 marker", frame_mk_no, (b == 1) ? 0 : 1, b);
      chk(b <= SYNC ? "R2 sync strobe" : (b > pe ? "R5 stuff strobe" : "R4 payload strobe"),
          ovh_stb_o, ovh, b);
      chk("R6 data", rx_data_o, la ? rb : 1, b);
      chk("R7 enable", pay_vld_o, (!ovh && la) ? 1 : 0, b);
      if (b == SYNC || b == SYNC + 1 || b == pe || b > pe || (b % 97) == 0)
        chk("R8 count", pay_cnt_o, ec, b);
      @(negedge clk_i);
    end
  endtask

  task automatic t_short_idle();       t_frame(1'b0, 1'b0, 0, 1'b0); endtask
  task automatic t_short_stuff();      t_frame(1'b0, 1'b1, 1, 1'b0); endtask
  task automatic t_short_toggle();     t_frame(1'b0, 1'b0, 2, 1'b1); endtask
  task automatic t_long_stuff();       t_frame(1'b1, 1'b1, 1, 1'b1); endtask
  task automatic t_long_plain();       t_frame(1'b1, 1'b0, 2, 1'b0); endtask
  task automatic t_short_after_long(); t_frame(1'b0, 1'b1, 1, 1'b0); endtask

  initial begin
    t_reset();
    t_short_idle();
    t_short_stuff();
    t_short_toggle();
    t_long_stuff();
    t_long_plain();
    t_short_after_long();
    #1;
    chk("R3 next marker", frame_mk_no, 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule